// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns the operand of a register-file access into a full physical data-memory address. The register file is split into banks of 2^OFF_W bytes each. The access comes from one of two paths. On the direct path, the offset is taken from the instruction and the bank from two bank-select bits held in the status register. On the indirect path, an address pointer register supplies the offset and one bank bit, and a separate indirect bank bit supplies the upper bank bit.

The decoder is purely combinational. It reports the selected bank and in-bank offset, and it classifies the location. Offsets below a parameterised boundary are special-function registers, and offsets at or above it are general-purpose RAM. Some locations are shared by every bank: a parameterised list of special-function offsets, and optionally a common RAM window at the top of each bank. Each shared location folds onto one canonical physical address, so every bank reaches the same storage cell. All other locations get a distinct physical address of the form bank × bank size + offset.

Top module: `rfdec_top`

## Requirements
- R1: With indirect_i = 0, bank_o equals rp_i (rp_i = 00, 01, 10, 11 selects bank 0, 1, 2, 3) and offset_o equals dir_off_i.
- R2: With indirect_i = 1, offset_o equals fsr_i[6:0], bank_o[0] equals fsr_i[7] and bank_o[1] equals irp_i.
- R3: Inputs of the path that is not selected have no effect on any output. On the direct path this covers fsr_i and irp_i; on the indirect path it covers rp_i and dir_off_i.
- R4: is_sfr_o is 1 exactly when offset_o is below the boundary SFR_LIMIT (default 20h).
- R5: is_gpr_o is the complement of is_sfr_o, so exactly one class flag is set for every access.
- R6: The default shared special-function offsets are 00h, 02h, 03h, 04h, 0Ah and 0Bh. For any of these, shared_o is 1 and phys_addr_o equals {CANON_BANK (default 0), offset_o} in every bank.
- R7: When the common window is enabled (default), every offset from COMMON_BASE (default 70h) to 7Fh gives shared_o = 1, is_gpr_o = 1 and phys_addr_o = {CANON_BANK, offset_o}.
- R8: Every location that is not shared gives shared_o = 0 and phys_addr_o = bank_o × 128 + offset_o (phys_addr_o[8:7] = bank, phys_addr_o[6:0] = offset).
- R9: bank_o always reports the bank that was selected, including for shared locations whose physical address is folded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| indirect_i | input | 1 | 0 selects the direct path, 1 selects the pointer path |
| dir_off_i | input | 7 | Offset field from the instruction |
| rp_i | input | 2 | Bank-select bits from the status register |
| fsr_i | input | 8 | Address pointer register |
| irp_i | input | 1 | Upper bank bit for pointer accesses |
| bank_o | output | 2 | Selected bank |
| offset_o | output | 7 | Selected in-bank offset |
| is_sfr_o | output | 1 | Location is a special-function register |
| is_gpr_o | output | 1 | Location is general-purpose RAM |
| shared_o | output | 1 | Location is shared by all banks and folded |
| phys_addr_o | output | 9 | Physical address into the register file |

## Verification
For every input combination, the checker tests five things: how each path forms bank and offset, that the class flags are exclusive and agree with the boundary, that folded locations carry the canonical bank, and that unshared locations keep their bank in the physical address. The checker cannot tell which offsets belong in the shared list or the common window. Only the bench can catch a wrong entry in that list or a misplaced window edge. It does so by sweeping every bank and offset on both paths, scrambling the inputs of the unselected path, and comparing against its own model.

// File: rtl/rfdec_pkg.sv
package rfdec_pkg;

   typedef enum logic {
      ACC_DIRECT   = 1'b0,
      ACC_INDIRECT = 1'b1
   } acc_mode_e;

endpackage

// File: rtl/rfdec_bank_sel.sv
module rfdec_bank_sel
   import rfdec_pkg::*;
#(
   parameter int OFF_W  = 7,
   parameter int BANK_W = 2
) (
   input  acc_mode_e           mode_i,
   input  logic [OFF_W-1:0]    dir_off_i,
   input  logic [BANK_W-1:0]   rp_i,
   input  logic [OFF_W:0]      fsr_i,
   input  logic [BANK_W-2:0]   irp_i,
   output logic [BANK_W-1:0]   bank_o,
   output logic [OFF_W-1:0]    off_o
);

   always_comb begin
      if (mode_i == ACC_INDIRECT) begin
         off_o  = fsr_i[OFF_W-1:0];
         bank_o = {irp_i, fsr_i[OFF_W]};
      end else begin
         off_o  = dir_off_i;
         bank_o = rp_i;
      end
   end

endmodule

// File: rtl/rfdec_mirror_match.sv
module rfdec_mirror_match #(
   parameter int                              OFF_W        = 7,
   parameter int                              SFR_LIMIT    = 32,
   parameter int                              MIRROR_COUNT = 6,
   parameter logic [MIRROR_COUNT*OFF_W-1:0]   MIRROR_LIST  = '0
) (
   input  logic [OFF_W-1:0] off_i,
   output logic             hit_o
);

   logic [MIRROR_COUNT-1:0] eq;

   for (genvar g = 0; g < MIRROR_COUNT; g++) begin : g_entry
      localparam logic [OFF_W-1:0] ENTRY = MIRROR_LIST[g*OFF_W +: OFF_W];
      if (int'(ENTRY) >= SFR_LIMIT) begin : g_bad_entry
         $error("shared list entry %0d lies outside the special-function range", g);
      end
      assign eq[g] = (off_i == ENTRY);
   end

   assign hit_o = |eq;

endmodule

// File: rtl/rfdec_region.sv
module rfdec_region #(
   parameter int OFF_W       = 7,
   parameter int SFR_LIMIT   = 32,
   parameter bit COMMON_EN   = 1'b1,
   parameter int COMMON_BASE = 112
) (
   input  logic [OFF_W-1:0] off_i,
   output logic             is_sfr_o,
   output logic             is_common_o
);

   localparam logic [OFF_W:0] LIMIT_EXT = SFR_LIMIT[OFF_W:0];

   assign is_sfr_o = ({1'b0, off_i} < LIMIT_EXT);

   if (COMMON_EN) begin : g_common
      localparam logic [OFF_W:0] BASE_EXT = COMMON_BASE[OFF_W:0];
      assign is_common_o = ({1'b0, off_i} >= BASE_EXT);
   end else begin : g_no_common
      assign is_common_o = 1'b0;
   end

endmodule

// File: rtl/rfdec_top.sv
module rfdec_top
   import rfdec_pkg::*;
#(
   parameter int                              OFF_W        = 7,
   parameter int                              BANK_W       = 2,
   parameter int                              SFR_LIMIT    = 32,
   parameter int                              MIRROR_COUNT = 6,
   parameter logic [MIRROR_COUNT*OFF_W-1:0]   MIRROR_LIST  =
      {7'h0B, 7'h0A, 7'h04, 7'h03, 7'h02, 7'h00},
   parameter bit                              COMMON_EN    = 1'b1,
   parameter int                              COMMON_BASE  = 112,
   parameter int                              CANON_BANK   = 0,
   localparam int                             PHYS_W       = OFF_W + BANK_W
) (
   input  logic                indirect_i,
   input  logic [OFF_W-1:0]    dir_off_i,
   input  logic [BANK_W-1:0]   rp_i,
   input  logic [OFF_W:0]      fsr_i,
   input  logic [BANK_W-2:0]   irp_i,
   output logic [BANK_W-1:0]   bank_o,
   output logic [OFF_W-1:0]    offset_o,
   output logic                is_sfr_o,
   output logic                is_gpr_o,
   output logic                shared_o,
   output logic [PHYS_W-1:0]   phys_addr_o
);

   localparam int                BANK_SIZE = 1 << OFF_W;
   localparam logic [BANK_W-1:0] CANON     = CANON_BANK[BANK_W-1:0];

   // elaboration-time parameter checks
   if (OFF_W < 2) begin : g_bad_off
      $error("OFF_W must be at least 2");
   end
   if (BANK_W < 2) begin : g_bad_bank
      $error("BANK_W must be at least 2");
   end
   if (SFR_LIMIT < 1 || SFR_LIMIT > BANK_SIZE) begin : g_bad_limit
      $error("SFR_LIMIT must lie within one bank");
   end
   if (MIRROR_COUNT < 1) begin : g_bad_count
      $error("MIRROR_COUNT must be at least 1");
   end
   if (COMMON_EN && (COMMON_BASE < SFR_LIMIT || COMMON_BASE >= BANK_SIZE)) begin : g_bad_common
      $error("COMMON_BASE must sit inside general-purpose space");
   end
   if (CANON_BANK < 0 || CANON_BANK >= (1 << BANK_W)) begin : g_bad_canon
      $error("CANON_BANK out of range");
   end

   acc_mode_e           mode;
   logic [BANK_W-1:0]   bank_sel;
   logic [OFF_W-1:0]    off_sel;
   logic                sfr_hit;
   logic                common_hit;
   logic                list_hit;
   logic                fold;

   assign mode = acc_mode_e'(indirect_i);

   rfdec_bank_sel #(
      .OFF_W  (OFF_W),
      .BANK_W (BANK_W)
   ) u_bank_sel (
      .mode_i    (mode),
      .dir_off_i (dir_off_i),
      .rp_i      (rp_i),
      .fsr_i     (fsr_i),
      .irp_i     (irp_i),
      .bank_o    (bank_sel),
      .off_o     (off_sel)
   );

   rfdec_region #(
      .OFF_W       (OFF_W),
      .SFR_LIMIT   (SFR_LIMIT),
      .COMMON_EN   (COMMON_EN),
      .COMMON_BASE (COMMON_BASE)
   ) u_region (
      .off_i       (off_sel),
      .is_sfr_o    (sfr_hit),
      .is_common_o (common_hit)
   );

   rfdec_mirror_match #(
      .OFF_W        (OFF_W),
      .SFR_LIMIT    (SFR_LIMIT),
      .MIRROR_COUNT (MIRROR_COUNT),
      .MIRROR_LIST  (MIRROR_LIST)
   ) u_mirror (
      .off_i (off_sel),
      .hit_o (list_hit)
   );

   assign fold        = list_hit | common_hit;

   assign bank_o      = bank_sel;
   assign offset_o    = off_sel;
   assign is_sfr_o    = sfr_hit;
   assign is_gpr_o    = ~sfr_hit;
   assign shared_o    = fold;
   assign phys_addr_o = fold ? {CANON, off_sel} : {bank_sel, off_sel};

endmodule

// File: rtl/rfdec_checker.sv
module rfdec_checker #(
   parameter int OFF_W      = 7,
   parameter int BANK_W     = 2,
   parameter int SFR_LIMIT  = 32,
   parameter int CANON_BANK = 0
) (
   input logic                       indirect_i,
   input logic [OFF_W-1:0]           dir_off_i,
   input logic [BANK_W-1:0]          rp_i,
   input logic [OFF_W:0]             fsr_i,
   input logic [BANK_W-2:0]          irp_i,
   input logic [BANK_W-1:0]          bank_o,
   input logic [OFF_W-1:0]           offset_o,
   input logic                       is_sfr_o,
   input logic                       is_gpr_o,
   input logic                       shared_o,
   input logic [OFF_W+BANK_W-1:0]    phys_addr_o
);

   localparam logic [OFF_W:0]      LIMIT_EXT = SFR_LIMIT[OFF_W:0];
   localparam logic [BANK_W-1:0]   CANON     = CANON_BANK[BANK_W-1:0];

   always_comb begin
      if (!indirect_i) begin
         p_direct_path_r1: assert (bank_o == rp_i && offset_o == dir_off_i)
            else $error("direct path bank/offset mismatch");
      end else begin
         p_pointer_path_r2: assert (bank_o == {irp_i, fsr_i[OFF_W]} && offset_o == fsr_i[OFF_W-1:0])
            else $error("pointer path bank/offset mismatch");
      end
      p_class_boundary_r4: assert (is_sfr_o == ({1'b0, offset_o} < LIMIT_EXT))
         else $error("class flag disagrees with boundary");
      p_class_exclusive_r5: assert ($onehot({is_sfr_o, is_gpr_o}))
         else $error("class flags not exclusive");
      if (shared_o) begin
         p_shared_fold_r6: assert (phys_addr_o == {CANON, offset_o})
            else $error("shared location not folded to canonical bank");
      end else begin
         p_banked_addr_r8: assert (phys_addr_o == {bank_o, offset_o})
            else $error("banked location address mismatch");
      end
   end

endmodule

bind rfdec_top rfdec_checker #(
   .OFF_W      (OFF_W),
   .BANK_W     (BANK_W),
   .SFR_LIMIT  (SFR_LIMIT),
   .CANON_BANK (CANON_BANK)
) u_rfdec_checker (
   .indirect_i  (indirect_i),
   .dir_off_i   (dir_off_i),
   .rp_i        (rp_i),
   .fsr_i       (fsr_i),
   .irp_i       (irp_i),
   .bank_o      (bank_o),
   .offset_o    (offset_o),
   .is_sfr_o    (is_sfr_o),
   .is_gpr_o    (is_gpr_o),
   .shared_o    (shared_o),
   .phys_addr_o (phys_addr_o)
);

// File: tb/tb_rfdec_top.sv
module tb_rfdec_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       indirect_i = 1'b0;
   logic [6:0] dir_off_i = '0;
   logic [1:0] rp_i = '0;
   logic [7:0] fsr_i = '0;
   logic [0:0] irp_i = '0;
   logic [1:0] bank_o;
   logic [6:0] offset_o;
   logic       is_sfr_o, is_gpr_o, shared_o;
   logic [8:0] phys_addr_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfdec_top dut (
      .indirect_i  (indirect_i),
      .dir_off_i   (dir_off_i),
      .rp_i        (rp_i),
      .fsr_i       (fsr_i),
      .irp_i       (irp_i),
      .bank_o      (bank_o),
      .offset_o    (offset_o),
      .is_sfr_o    (is_sfr_o),
      .is_gpr_o    (is_gpr_o),
      .shared_o    (shared_o),
      .phys_addr_o (phys_addr_o)
   );

   // bench model of the shared locations
   function automatic bit model_shared(input logic [6:0] off);
      case (off)
         7'h00, 7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B: return 1'b1;
         default: return (off >= 7'h70);
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (ind=%0b doff=%0h rp=%0h fsr=%0h irp=%0h)",
                  req, act, exp, indirect_i, dir_off_i, rp_i, fsr_i, irp_i);
      end
   endtask

   task automatic apply(input bit ind, input logic [6:0] doff, input logic [1:0] rp,
                        input logic [7:0] fsr, input logic irp);
      logic [1:0] eb;
      logic [6:0] eo;
      bit         sh;
      @(posedge clk);
      indirect_i = ind;
      dir_off_i  = doff;
      rp_i       = rp;
      fsr_i      = fsr;
      irp_i      = irp;
      @(negedge clk);
      eb = ind ? {irp, fsr[7]} : rp;
      eo = ind ? fsr[6:0] : doff;
      sh = model_shared(eo);
      // R1 / R2 / R3: path selection with the other path scrambled; R9: bank kept
      check(ind ? "R2_R3_R9 bank" : "R1_R3_R9 bank", int'(bank_o), int'(eb));
      check(ind ? "R2_R3 offset" : "R1_R3 offset", int'(offset_o), int'(eo));
      check("R4 is_sfr", int'(is_sfr_o), int'(eo < 7'h20));
      check("R5 is_gpr", int'(is_gpr_o), int'(eo >= 7'h20));
      check(sh ? "R6_R7 shared" : "R8 shared", int'(shared_o), int'(sh));
      check(sh ? "R6_R7 phys" : "R8 phys", int'(phys_addr_o),
            sh ? int'(eo) : int'(eb) * 128 + int'(eo));
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-state inputs: all zero gives bank 0, offset 0, shared SFR
      @(negedge clk);
      check("R1 reset bank", int'(bank_o), 0);
      check("R6 reset phys", int'(phys_addr_o), 0);
      check("R6 reset shared", int'(shared_o), 1);

      // every bank and offset on the direct path, pointer inputs scrambled
      for (int b = 0; b < 4; b++)
         for (int o = 0; o < 128; o++)
            apply(1'b0, 7'(o), 2'(b), 8'($urandom), 1'($urandom));

      // every pointer value with both upper bank bits, direct inputs scrambled
      for (int ib = 0; ib < 2; ib++)
         for (int f = 0; f < 256; f++)
            apply(1'b1, 7'($urandom), 2'($urandom), 8'(f), 1'(ib));

      // directed corners: boundary, common edge, shared entries in top bank
      apply(1'b0, 7'h1F, 2'd3, 8'hFF, 1'b1);
      apply(1'b0, 7'h20, 2'd3, 8'h00, 1'b0);
      apply(1'b0, 7'h6F, 2'd2, 8'h00, 1'b0);
      apply(1'b0, 7'h70, 2'd2, 8'h00, 1'b0);
      apply(1'b1, 7'h00, 2'd0, 8'h8B, 1'b1);
      apply(1'b1, 7'h00, 2'd0, 8'h81, 1'b1);

      // random mix
      for (int i = 0; i < 1500; i++)
         apply(1'($urandom), 7'($urandom), 2'($urandom), 8'($urandom), 1'($urandom));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule